// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked system read and write an external asynchronous static RAM holding 131,072 bytes. The client issues one word per request on a valid/ready handshake, with a 17-bit address, a byte of write data and a read/write flag. The controller sequences the memory's select, output-enable and write-enable pins and the shared data bus, and returns each read byte with a one-cycle valid strobe.

The memory is selected only while its active-low enable is low and its active-high enable is high, so the controller always moves the two together. Every phase length comes from a nanosecond parameter divided by the clock period and rounded up to whole clocks, with a floor of one clock. A read holds the address, both enables and output enable for the read count, then captures the bus on the last clock of that phase. A write first spends one clock selecting the memory, then holds write enable low and drives data for the pulse count, then raises write enable and keeps driving data one more clock so that hold time is met. Output enable stays inactive for the whole write, so the memory never drives the bus while the controller does.

Top module: `asram_ctrl_top`

## Requirements
- R1: After reset and between accesses the memory is deselected (active-low enable 1, active-high enable 0), write enable and output enable are 1, the data driver is off, request ready is 1 and read valid is 0.
- R2: A read holds both enables active, output enable 0, write enable 1 and the driver off, with the address unchanged, for RD_CYC clocks (11 with the default 55 ns at a 5 ns clock). The bus is captured on the last of those clocks, and read valid rises on the clock that follows.
- R3: A write selects the memory for one clock with write enable 1, then holds write enable 0 for WP_CYC clocks (11 by default) with the driver on and the request data stable. Output enable stays 1 for the whole write, and ready returns WP_CYC+3 clocks after acceptance.
- R4: On the clock after write enable returns to 1, the driver stays on with the same data. It is off on the clock after that.
- R5: Output enable and write enable are never 0 together, and the driver is never on while output enable is 0.
- R6: Ready is 0 from the clock after acceptance until the access completes, and a request presented while ready is 0 has no effect.
- R7: The driver is off on the first clock of every selection of the memory.
- R8: The write that ends under R3/R4 stores the request data at the request address, and a later read of that address returns it.
- R9: Read valid is high for exactly one clock per read, and the read data stays stable after that pulse.
- R10: The active-low enable is always the inverse of the active-high enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 17 | Word address |
| reqWdata | input | 8 | Write data |
| reqReady | output | 1 | Controller accepts a request this clock |
| rspValid | output | 1 | One-cycle read data strobe |
| rspData | output | 8 | Captured read data |
| sramCeN | output | 1 | Active-low chip enable |
| sramCe2 | output | 1 | Active-high chip enable |
| sramOeN | output | 1 | Active-low output enable |
| sramWeN | output | 1 | Active-low write enable |
| sramAddr | output | 17 | Address bus |
| sramDqOut | output | 8 | Data bus value driven by the controller |
| sramDqOe | output | 1 | Enable of the controller's data bus driver |
| sramDqIn | input | 8 | Data bus value read from the memory |

## Verification
On every cycle the assertions check the pin rules: the two enables stay complementary, output enable and write enable are never low together, the driver stays off while the memory may drive the bus and on the first clock of each selection, data is held after write enable rises, the address does not move during an access, ready drops after acceptance, and read valid lasts one clock. Only the bench scenarios can show the phase lengths in clocks, the data that actually reaches a memory model, capture at the moment access time has elapsed, and that a request offered while the controller is busy changes nothing. These run with back-to-back mixed traffic, at both ends of the address space and at unwritten locations.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_WSETUP = 3'd2,
    ST_WPULSE = 3'd3,
    ST_WHOLD  = 3'd4
  } state_e;

  // Strobes from control to datapath and pins
  typedef struct packed {
    logic ceN;
    logic ce2;
    logic oeN;
    logic weN;
    logic dqOe;
    logic load;
    logic capture;
  } strobe_t;

  // Nanoseconds to whole clocks, rounded up, never below one
  function automatic int ns2cyc(input int ns, input int periodNs);
    int c;
    c = (ns + periodNs - 1) / periodNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/asram_ctrl_fsm.sv
module asram_ctrl_fsm
  import asram_pkg::*;
#(
  parameter int RD_CYC = 11,
  parameter int WP_CYC = 11
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output strobe_t strb
);

  localparam int MAX_CYC = (RD_CYC > WP_CYC) ? RD_CYC : WP_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  state_e           state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;

  // Registered pin levels, decoded from the next state
  logic pinCeN, pinCe2, pinOeN, pinWeN, pinDqOe;
  logic nxtCeN, nxtCe2, nxtOeN, nxtWeN, nxtDqOe;
  logic accept;

  assign reqReady = (state == ST_IDLE);
  assign accept   = reqReady && reqValid;

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (reqWrite) begin
            stateNext = ST_WSETUP;
            cntNext   = '0;
          end else begin
            stateNext = ST_READ;
            cntNext   = CNT_W'(RD_CYC - 1);
          end
        end
      end
      ST_READ: begin
        if (cnt == '0) stateNext = ST_IDLE;
        else           cntNext   = cnt - 1'b1;
      end
      ST_WSETUP: begin
        stateNext = ST_WPULSE;
        cntNext   = CNT_W'(WP_CYC - 1);
      end
      ST_WPULSE: begin
        if (cnt == '0) stateNext = ST_WHOLD;
        else           cntNext   = cnt - 1'b1;
      end
      ST_WHOLD: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    nxtCeN  = 1'b1;
    nxtCe2  = 1'b0;
    nxtOeN  = 1'b1;
    nxtWeN  = 1'b1;
    nxtDqOe = 1'b0;
    unique case (stateNext)
      ST_READ: begin
        nxtCeN = 1'b0;
        nxtCe2 = 1'b1;
        nxtOeN = 1'b0;
      end
      ST_WSETUP: begin
        nxtCeN = 1'b0;
        nxtCe2 = 1'b1;
      end
      ST_WPULSE: begin
        nxtCeN  = 1'b0;
        nxtCe2  = 1'b1;
        nxtWeN  = 1'b0;
        nxtDqOe = 1'b1;
      end
      ST_WHOLD: begin
        nxtCeN  = 1'b0;
        nxtCe2  = 1'b1;
        nxtDqOe = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      pinCeN  <= 1'b1;
      pinCe2  <= 1'b0;
      pinOeN  <= 1'b1;
      pinWeN  <= 1'b1;
      pinDqOe <= 1'b0;
    end else begin
      state   <= stateNext;
      cnt     <= cntNext;
      pinCeN  <= nxtCeN;
      pinCe2  <= nxtCe2;
      pinOeN  <= nxtOeN;
      pinWeN  <= nxtWeN;
      pinDqOe <= nxtDqOe;
    end
  end

  always_comb begin
    strb.ceN     = pinCeN;
    strb.ce2     = pinCe2;
    strb.oeN     = pinOeN;
    strb.weN     = pinWeN;
    strb.dqOe    = pinDqOe;
    strb.load    = accept;
    strb.capture = (state == ST_READ) && (cnt == '0);
  end

  // R10: both enables move together
  p_enable_pair_r10: assert property (@(posedge clk) disable iff (!rstN)
    pinCeN == !pinCe2);

  // R5: no read and write enable together, no drive against the memory
  p_no_oe_we_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(!pinOeN && !pinWeN) && !(pinDqOe && !pinOeN));

  // R7: driver off on the first clock of a selection
  p_quiet_start_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pinCeN) |-> !pinDqOe);

  // R4: data still driven on the clock after write enable rises
  p_write_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(pinWeN) && !pinCeN) |-> pinDqOe);

  // R6: ready drops after acceptance
  p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !reqReady);

  // R1: idle keeps the memory deselected and the bus released
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && $past(reqReady)) |-> (pinCeN && !pinDqOe && pinWeN && pinOeN));

endmodule

// File: rtl/asram_datapath.sv
module asram_datapath
  import asram_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] sramDqIn,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramDqOut,
  output logic [DATA_W-1:0] rspData,
  output logic              rspValid
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;
  logic              rvalidQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
    end else if (strb.load) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdataQ  <= '0;
      rvalidQ <= 1'b0;
    end else begin
      rvalidQ <= strb.capture;
      if (strb.capture) rdataQ <= sramDqIn;
    end
  end

  assign sramAddr  = addrQ;
  assign sramDqOut = wdataQ;
  assign rspData   = rdataQ;
  assign rspValid  = rvalidQ;

  // R9: read valid lasts a single clock
  p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    rvalidQ |=> !rvalidQ);

  // R2: the address stays put while the memory is selected
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.ceN && $past(!strb.ceN)) |-> $stable(addrQ));

  // R3: write data stable while driven
  p_data_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dqOe && $past(strb.dqOe)) |-> $stable(wdataQ));

endmodule

// File: rtl/asram_ctrl_top.sv
module asram_ctrl_top
  import asram_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int CLK_NS     = 5,
  parameter int T_RC_NS    = 55,
  parameter int T_AA_NS    = 55,
  parameter int T_ACS_NS   = 55,
  parameter int T_WP_NS    = 55,
  parameter int T_CW_NS    = 55,
  parameter int T_DW_NS    = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              sramCeN,
  output logic              sramCe2,
  output logic              sramOeN,
  output logic              sramWeN,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramDqOut,
  output logic              sramDqOe,
  input  logic [DATA_W-1:0] sramDqIn
);

  localparam int RD_CYC = max3(ns2cyc(T_RC_NS, CLK_NS), ns2cyc(T_AA_NS, CLK_NS),
                               ns2cyc(T_ACS_NS, CLK_NS));
  localparam int WP_CYC = max3(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_CW_NS, CLK_NS),
                               ns2cyc(T_DW_NS, CLK_NS));

  strobe_t strb;

  asram_ctrl_fsm #(
    .RD_CYC(RD_CYC),
    .WP_CYC(WP_CYC)
  ) u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .strb    (strb)
  );

  asram_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .sramDqIn (sramDqIn),
    .sramAddr (sramAddr),
    .sramDqOut(sramDqOut),
    .rspData  (rspData),
    .rspValid (rspValid)
  );

  assign sramCeN  = strb.ceN;
  assign sramCe2  = strb.ce2;
  assign sramOeN  = strb.oeN;
  assign sramWeN  = strb.weN;
  assign sramDqOe = strb.dqOe;

endmodule

// File: tb/tb_asram_ctrl_top.sv
`timescale 1ns/1ps
module tb_asram_ctrl_top;

  localparam int CLK_NS = 5;
  localparam int RD_EXP = (55 + CLK_NS - 1) / CLK_NS;  // 11
  localparam int WP_EXP = (55 + CLK_NS - 1) / CLK_NS;  // 11

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [16:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        reqReady, rspValid;
  logic [7:0]  rspData;
  logic        sramCeN, sramCe2, sramOeN, sramWeN, sramDqOe;
  logic [16:0] sramAddr;
  logic [7:0]  sramDqOut;
  logic [7:0]  sramDqIn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  asram_ctrl_top dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .rspValid(rspValid), .rspData(rspData), .sramCeN(sramCeN),
    .sramCe2(sramCe2), .sramOeN(sramOeN), .sramWeN(sramWeN),
    .sramAddr(sramAddr), .sramDqOut(sramDqOut), .sramDqOe(sramDqOe),
    .sramDqIn(sramDqIn)
  );

  // Memory model contents and bench reference contents
  logic [7:0] model  [int];
  logic [7:0] refMem [int];

  function automatic logic [7:0] dflt(input logic [16:0] a);
    return a[7:0] ^ a[16:9] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] modelRead(input logic [16:0] a);
    return model.exists(int'(a)) ? model[int'(a)] : dflt(a);
  endfunction

  function automatic logic [7:0] expRead(input logic [16:0] a);
    return refMem.exists(int'(a)) ? refMem[int'(a)] : dflt(a);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Pin monitor, sampled at the falling edge
  int          rdCnt = 0;
  int          wpCnt = 0;
  bit          prevSel = 1'b0, prevWeLow = 1'b0, holdPend = 1'b0, prevRd = 1'b0;
  logic [16:0] prevAddr = '0;
  logic [7:0]  prevData = '0;

  assign sramDqIn = (rdCnt >= RD_EXP) ? modelRead(sramAddr) : ~modelRead(sramAddr);

  always @(negedge clk) begin
    bit sel, rd;
    if (rstN) begin
      sel = !sramCeN && sramCe2;
      rd  = sel && sramWeN && !sramOeN;
      if (sramCeN != !sramCe2) check(1'b0, "R10 enables", sramCeN, !sramCe2);
      if (!sramOeN && !sramWeN) check(1'b0, "R5 oe/we both low", 0, 1);
      if (sramDqOe && !sramOeN) check(1'b0, "R5 drive during read", 1, 0);
      if (sel && !prevSel && sramDqOe) check(1'b0, "R7 driver on at select", 1, 0);
      if (sel && prevSel && sramAddr != prevAddr)
        check(1'b0, "R2 address moved", sramAddr, prevAddr);
      if (sel && !sramWeN && !sramOeN) check(1'b0, "R3 oe during write", 0, 1);
      rdCnt = rd ? ((prevRd && sramAddr == prevAddr) ? rdCnt + 1 : 1) : 0;
      if (holdPend) begin
        check(!sramDqOe, "R4 release after hold", sramDqOe, 0);
        holdPend = 1'b0;
      end
      if (sel && !sramWeN) begin
        if (!prevWeLow) check(prevSel, "R3 setup clock", prevSel, 1);
        else if (sramDqOut != prevData) check(1'b0, "R3 data moved", sramDqOut, prevData);
        if (!sramDqOe) check(1'b0, "R3 driver off in pulse", 0, 1);
        wpCnt++;
      end else if (prevWeLow) begin
        check(wpCnt == WP_EXP, "R3 pulse width", wpCnt, WP_EXP);
        check(sramDqOe && sramDqOut == prevData && sel, "R4 hold data",
              sramDqOut, prevData);
        model[int'(sramAddr)] = sramDqOut;
        holdPend = 1'b1;
        wpCnt = 0;
      end
      prevSel   = sel;
      prevRd    = rd;
      prevWeLow = sel && !sramWeN;
      prevAddr  = sramAddr;
      prevData  = sramDqOut;
    end
  end

  task automatic waitReady();
    while (!reqReady) @(negedge clk);
  endtask

  task automatic doWrite(input logic [16:0] a, input logic [7:0] d, input bit intrude,
                         input logic [16:0] ia);
    int lat;
    waitReady();
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    check(!reqReady, "R6 busy after write accept", reqReady, 0);
    refMem[int'(a)] = d;
    lat = 1;
    if (intrude) begin
      // Offer a request while busy, then withdraw it
      reqValid = 1'b1; reqWrite = 1'b1; reqAddr = ia; reqWdata = ~expRead(ia);
      repeat (3) begin @(negedge clk); lat++; end
      reqValid = 1'b0;
    end
    while (!reqReady && lat < 100) begin @(negedge clk); lat++; end
    check(lat == WP_EXP + 3, "R3 write length", lat, WP_EXP + 3);
    check(sramCeN && !sramCe2 && !sramDqOe && sramWeN && sramOeN,
          "R1 idle after write", {sramCeN, sramCe2, sramDqOe, sramWeN, sramOeN}, 5'b10011);
  endtask

  task automatic doRead(input logic [16:0] a);
    int lat;
    logic [7:0] got;
    waitReady();
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
    check(!reqReady, "R6 busy after read accept", reqReady, 0);
    lat = 1;
    while (!rspValid && lat < 100) begin @(negedge clk); lat++; end
    check(lat == RD_EXP + 1, "R2 read latency", lat, RD_EXP + 1);
    check(rspData == expRead(a), "R8 read data", rspData, expRead(a));
    got = rspData;
    @(negedge clk);
    check(!rspValid && rspData == got, "R9 single pulse", rspValid, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(reqReady && !rspValid && sramCeN && !sramCe2 && sramWeN && sramOeN && !sramDqOe,
          "R1 reset state", {reqReady, rspValid, sramCeN, sramCe2, sramWeN, sramOeN, sramDqOe},
          7'b1010110);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(reqReady && sramCeN && !sramDqOe, "R1 idle after reset",
          {reqReady, sramCeN, sramDqOe}, 3'b110);

    // Directed corners
    doRead(17'h00123);                         // unwritten location
    doWrite(17'h00000, 8'hA5, 1'b0, '0);
    doWrite(17'h1FFFF, 8'h3C, 1'b0, '0);
    doRead(17'h00000);
    doRead(17'h1FFFF);
    doWrite(17'h00042, 8'hFF, 1'b0, '0);
    doRead(17'h00042);                         // write then read, same address
    doWrite(17'h00042, 8'h00, 1'b1, 17'h00077); // R6: busy request ignored
    doRead(17'h00077);
    doRead(17'h00042);

    // Constrained random mixed traffic over a small window plus extremes
    for (int i = 0; i < 300; i++) begin
      logic [16:0] a;
      int sel;
      sel = $urandom % 8;
      if (sel == 0)      a = 17'h1FFFF - 17'($urandom % 4);
      else if (sel == 1) a = 17'($urandom % 4);
      else               a = 17'h10000 + 17'($urandom % 24);
      if ($urandom % 2) doWrite(a, 8'($urandom), 1'b0, '0);
      else              doRead(a);
    end

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      done = 1'b1;
      check(1'b0, "watchdog R1", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule